// File: doc/BRIEF.md
# Dual-Path Converter Clock Divider Tree

This block derives clock-enable pulses for a pair of audio converter paths from one master clock. Each path has three integer divide stages in a fixed order. The first stage divides the master clock by a ratio N and gives the converter-clock enable. The second stage divides that enable by M and gives the modulator-clock enable. The third stage is an oversampling-ratio counter. It divides the modulator enable by OSR and gives the sample-rate strobe. Because every intermediate rate is brought out, different factor choices that reach the same final rate can be told apart by their intermediate pulse rates. For example, with a 24.576 MHz master clock, the factor sets 2·6·256 and 2·12·128 both give 8 kHz, but their modulator rates are 2.048 MHz and 1.024 MHz.

Chain 0 is the playback path and chain 1 is the record path. Both chains count the same master clock, but each has its own ratios and its own run control. Ratios are loaded through a per-chain write strobe. A write is accepted only while that chain is stopped. Starting a chain clears all three of its counters, so the first sample strobe lands exactly N·M·OSR master cycles after the start. A ratio of zero is illegal, and a chain holding any zero ratio never runs.

Top module: `conv_clk_tree`

## Requirements
- R1: While a chain runs, its converter enable (convEn) is a one-cycle pulse that is high exactly in running cycles k = N, 2N, 3N, …. The first running cycle, k = 1, is the cycle after the clock edge that samples chainEn high.
- R2: The modulator enable (modEn) is high exactly in running cycles that are multiples of N·M, and it is never high without convEn.
- R3: The sample strobe (fsStrobe) is high exactly in running cycles that are multiples of N·M·OSR, and it is never high without modEn. For example, playback 2·2·768 and record 2·6·256 both give a period of 3072 cycles.
- R4: After a start, the first convEn, modEn and fsStrobe pulses arrive in running cycles N, N·M and N·M·OSR.
- R5: A ratio of 1 passes every incoming enable through. With N = 1, convEn is high in every running cycle.
- R6: A write on cfgWe while the chain runs is ignored, and the chain keeps its old periods after a restart. A write while the chain is stopped takes effect at the next start.
- R7: While any of a chain's stored N, M or OSR is 0, that chain produces no pulses even with chainEn held high.
- R8: The two chains are independent. Starting, stopping or configuring one does not change the pulses of the other.
- R9: After reset, all outputs are low and all stored ratios are 0, so neither chain runs until it has been written.
- R10: One cycle after chainEn is sampled low, the chain's outputs are low. A later start begins the count again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 2 | Per-chain ratio write strobe (bit 0 playback, bit 1 record) |
| cfgN | input | 2×NW | First-stage ratio N per chain |
| cfgM | input | 2×MW | Second-stage ratio M per chain |
| cfgOsr | input | 2×OW | Oversampling ratio per chain |
| chainEn | input | 2 | Per-chain run request |
| convEn | output | 2 | Converter-clock enable pulse per chain |
| modEn | output | 2 | Modulator-clock enable pulse per chain |
| fsStrobe | output | 2 | Sample-rate strobe per chain |

## Verification
The bench builds the block with its default widths: NW = 8, MW = 8, OW = 10. These widths hold the full ratios 768, 256 and 128 as well as the small ones. With these widths, the bench sweeps every ratio triple with each factor in 1 to 3 on alternating chains and checks every pulse position against multiples of the computed products. It also runs the wide 8 kHz settings on both chains at once, covering two full sample periods. The bench further covers the write-while-running and zero-ratio cases, and stop and restart.

// File: rtl/conv_clk_pkg.sv
package conv_clk_pkg;
  localparam int CHAINS   = 2;
  localparam int PLAY_IDX = 0;
  localparam int REC_IDX  = 1;

  // Control-to-datapath strobes for one chain.
  typedef struct packed {
    logic tick;   // count one master cycle
    logic clear;  // hold all counters at zero
  } strobe_t;
endpackage

// File: rtl/conv_clk_stage.sv
module conv_clk_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         inEn,
  input  logic [W-1:0] ratio,
  output logic         outEn
);
  logic [W-1:0] cnt;
  logic         atLast;

  assign atLast = (cnt == ratio - W'(1));
  assign outEn  = inEn && atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (inEn) begin
      cnt <= atLast ? '0 : cnt + W'(1);
    end
  end
endmodule

// File: rtl/conv_clk_ctrl.sv
module conv_clk_ctrl
  import conv_clk_pkg::*;
#(
  parameter int NW = 8,
  parameter int MW = 8,
  parameter int OW = 10
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [CHAINS-1:0]              cfgWe,
  input  logic [CHAINS-1:0][NW-1:0]      cfgN,
  input  logic [CHAINS-1:0][MW-1:0]      cfgM,
  input  logic [CHAINS-1:0][OW-1:0]      cfgOsr,
  input  logic [CHAINS-1:0]              chainEn,
  output logic [CHAINS-1:0][NW-1:0]      nQ,
  output logic [CHAINS-1:0][MW-1:0]      mQ,
  output logic [CHAINS-1:0][OW-1:0]      oQ,
  output logic [CHAINS-1:0]              chainRun,
  output strobe_t [CHAINS-1:0]           strb
);
  for (genvar g = 0; g < CHAINS; g++) begin : gChain
    logic [NW-1:0] nReg, nNext;
    logic [MW-1:0] mReg, mNext;
    logic [OW-1:0] oReg, oNext;
    logic          runReg;
    logic          accept;
    logic          legal;

    // Writes land only while the chain is stopped.
    assign accept = cfgWe[g] && !runReg;
    assign nNext  = accept ? cfgN[g]   : nReg;
    assign mNext  = accept ? cfgM[g]   : mReg;
    assign oNext  = accept ? cfgOsr[g] : oReg;
    // Legality is judged on the values that will be held next cycle.
    assign legal  = (nNext != '0) && (mNext != '0) && (oNext != '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        nReg   <= '0;
        mReg   <= '0;
        oReg   <= '0;
        runReg <= 1'b0;
      end else begin
        nReg   <= nNext;
        mReg   <= mNext;
        oReg   <= oNext;
        runReg <= chainEn[g] && legal;
      end
    end

    assign nQ[g]         = nReg;
    assign mQ[g]         = mReg;
    assign oQ[g]         = oReg;
    assign chainRun[g]   = runReg;
    assign strb[g].tick  = runReg;
    assign strb[g].clear = !runReg;
  end
endmodule

// File: rtl/conv_clk_dpath.sv
module conv_clk_dpath
  import conv_clk_pkg::*;
#(
  parameter int NW = 8,
  parameter int MW = 8,
  parameter int OW = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t [CHAINS-1:0]      strb,
  input  logic [CHAINS-1:0][NW-1:0] nQ,
  input  logic [CHAINS-1:0][MW-1:0] mQ,
  input  logic [CHAINS-1:0][OW-1:0] oQ,
  output logic [CHAINS-1:0]         convEn,
  output logic [CHAINS-1:0]         modEn,
  output logic [CHAINS-1:0]         fsStrobe
);
  for (genvar g = 0; g < CHAINS; g++) begin : gChain
    logic convPulse, modPulse, fsPulse;

    conv_clk_stage #(.W(NW)) stageConv_i (
      .clk(clk), .rstN(rstN), .clear(strb[g].clear),
      .inEn(strb[g].tick), .ratio(nQ[g]), .outEn(convPulse));

    conv_clk_stage #(.W(MW)) stageMod_i (
      .clk(clk), .rstN(rstN), .clear(strb[g].clear),
      .inEn(convPulse), .ratio(mQ[g]), .outEn(modPulse));

    conv_clk_stage #(.W(OW)) stageOsr_i (
      .clk(clk), .rstN(rstN), .clear(strb[g].clear),
      .inEn(modPulse), .ratio(oQ[g]), .outEn(fsPulse));

    assign convEn[g]   = convPulse;
    assign modEn[g]    = modPulse;
    assign fsStrobe[g] = fsPulse;
  end
endmodule

// File: rtl/conv_clk_tree.sv
module conv_clk_tree
  import conv_clk_pkg::*;
#(
  parameter int NW = 8,
  parameter int MW = 8,
  parameter int OW = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [1:0]                cfgWe,
  input  logic [1:0][NW-1:0]        cfgN,
  input  logic [1:0][MW-1:0]        cfgM,
  input  logic [1:0][OW-1:0]        cfgOsr,
  input  logic [1:0]                chainEn,
  output logic [1:0]                convEn,
  output logic [1:0]                modEn,
  output logic [1:0]                fsStrobe
);
  logic [CHAINS-1:0][NW-1:0] nQ;
  logic [CHAINS-1:0][MW-1:0] mQ;
  logic [CHAINS-1:0][OW-1:0] oQ;
  logic [CHAINS-1:0]         chainRun;
  strobe_t [CHAINS-1:0]      strb;

  conv_clk_ctrl #(.NW(NW), .MW(MW), .OW(OW)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgN(cfgN), .cfgM(cfgM),
    .cfgOsr(cfgOsr), .chainEn(chainEn), .nQ(nQ), .mQ(mQ), .oQ(oQ),
    .chainRun(chainRun), .strb(strb));

  conv_clk_dpath #(.NW(NW), .MW(MW), .OW(OW)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .nQ(nQ), .mQ(mQ), .oQ(oQ),
    .convEn(convEn), .modEn(modEn), .fsStrobe(fsStrobe));
endmodule

// File: rtl/conv_clk_chk.sv
module conv_clk_chk #(
  parameter int NW = 8,
  parameter int MW = 8,
  parameter int OW = 10
) (
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          chainEn,
  input logic [1:0]          convEn,
  input logic [1:0]          modEn,
  input logic [1:0]          fsStrobe,
  input logic [1:0]          chainRun,
  input logic [1:0][NW-1:0]  nQ,
  input logic [1:0][MW-1:0]  mQ,
  input logic [1:0][OW-1:0]  oQ
);
  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R9: assert ((convEn | modEn | fsStrobe) == 2'b00)
        else $error("outputs active during reset");
    end
  end

  for (genvar g = 0; g < 2; g++) begin : gChk
    assert_mod_in_conv_R2: assert property (@(posedge clk) disable iff (!rstN)
      modEn[g] |-> convEn[g]);
    assert_fs_in_mod_R3: assert property (@(posedge clk) disable iff (!rstN)
      fsStrobe[g] |-> modEn[g]);
    assert_unit_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
      (chainRun[g] && nQ[g] == NW'(1)) |-> convEn[g]);
    assert_hold_cfg_R6: assert property (@(posedge clk) disable iff (!rstN)
      chainRun[g] |=> ($stable(nQ[g]) && $stable(mQ[g]) && $stable(oQ[g])));
    assert_zero_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
      (nQ[g] == '0 || mQ[g] == '0 || oQ[g] == '0) |-> !convEn[g]);
    assert_stop_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
      !chainEn[g] |=> !(convEn[g] || modEn[g] || fsStrobe[g]));
  end
endmodule

bind conv_clk_tree conv_clk_chk #(.NW(NW), .MW(MW), .OW(OW)) chk_i (
  .clk(clk), .rstN(rstN), .chainEn(chainEn), .convEn(convEn),
  .modEn(modEn), .fsStrobe(fsStrobe), .chainRun(chainRun),
  .nQ(nQ), .mQ(mQ), .oQ(oQ));

// File: tb/conv_clk_tree_tb_top.sv
`timescale 1ns/1ps
module conv_clk_tree_tb_top;
  localparam int NW = 8, MW = 8, OW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cfgWe = '0;
  logic [1:0][NW-1:0] cfgN = '0;
  logic [1:0][MW-1:0] cfgM = '0;
  logic [1:0][OW-1:0] cfgOsr = '0;
  logic [1:0] chainEn = '0;
  logic [1:0] convEn, modEn, fsStrobe;

  always #2 clk = ~clk;

  conv_clk_tree #(.NW(NW), .MW(MW), .OW(OW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgN(cfgN), .cfgM(cfgM),
    .cfgOsr(cfgOsr), .chainEn(chainEn), .convEn(convEn), .modEn(modEn),
    .fsStrobe(fsStrobe));

  int errors = 0, checks = 0, cycles = 0;
  bit finished = 0;
  // Expected model per chain: ratios, whether pulses are expected, running-cycle index.
  int expN[2], expM[2], expO[2];
  bit expAct[2];
  int kc[2];
  int bad[2][3], badK[2][3], badAct[2][3], badExp[2][3];

  always @(posedge clk) cycles++;

  initial begin
    while (cycles < 150000 && !finished) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Write ratios into the selected chains (stimulus at negedge, one edge).
  task automatic writeCfg(input int ch, input int n, input int m, input int o);
    @(negedge clk);
    cfgWe[ch] = 1'b1; cfgN[ch] = NW'(n); cfgM[ch] = MW'(m); cfgOsr[ch] = OW'(o);
    @(negedge clk);
    cfgWe[ch] = 1'b0;
  endtask

  task automatic clearWin();
    for (int c = 0; c < 2; c++) begin
      kc[c] = 0;
      for (int s = 0; s < 3; s++) begin
        bad[c][s] = 0; badK[c][s] = 0; badAct[c][s] = 0; badExp[c][s] = 0;
      end
    end
  endtask

  // Observe a number of clock cycles, comparing every pulse to the model.
  task automatic observe(input int num);
    for (int i = 0; i < num; i++) begin
      @(posedge clk); #1;
      for (int c = 0; c < 2; c++) begin
        bit e[3];
        bit a[3];
        kc[c]++;
        e[0] = expAct[c] && (kc[c] % expN[c] == 0);
        e[1] = expAct[c] && (kc[c] % (expN[c] * expM[c]) == 0);
        e[2] = expAct[c] && (kc[c] % (expN[c] * expM[c] * expO[c]) == 0);
        a[0] = convEn[c]; a[1] = modEn[c]; a[2] = fsStrobe[c];
        for (int s = 0; s < 3; s++) begin
          if (a[s] != e[s]) begin
            if (bad[c][s] == 0) begin
              badK[c][s] = kc[c]; badAct[c][s] = int'(a[s]); badExp[c][s] = int'(e[s]);
            end
            bad[c][s]++;
          end
        end
      end
    end
  endtask

  task automatic judge(input string tag);
    string nm[3];
    nm[0] = "convEn"; nm[1] = "modEn"; nm[2] = "fsStrobe";
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 3; s++)
        check(bad[c][s] == 0,
              $sformatf("%s chain%0d %s N=%0d M=%0d OSR=%0d at k=%0d", tag, c, nm[s],
                        expN[c], expM[c], expO[c], badK[c][s]),
              badAct[c][s], badExp[c][s]);
    clearWin();
  endtask

  task automatic startMask(input bit [1:0] mask);
    @(negedge clk);
    chainEn = mask;
    clearWin();
  endtask

  task automatic stopAll();
    @(negedge clk);
    chainEn = 2'b00;
    // R10: one cycle after chainEn sampled low, all outputs low.
    @(posedge clk); #1;
    check((convEn | modEn | fsStrobe) == 2'b00, "R10 outputs low after stop",
          int'({convEn, modEn, fsStrobe}), 0);
  endtask

  initial begin
    clearWin();
    for (int c = 0; c < 2; c++) begin
      expN[c] = 1; expM[c] = 1; expO[c] = 1; expAct[c] = 0;
    end
    repeat (3) @(posedge clk); #1;
    check((convEn | modEn | fsStrobe) == 2'b00, "R9 outputs low in reset",
          int'({convEn, modEn, fsStrobe}), 0);
    @(negedge clk); rstN = 1'b1;

    // R9: unwritten ratios are 0, so enabling gives no pulses.
    startMask(2'b11);
    observe(20);
    judge("R9 unconfigured chains idle");
    stopAll();

    // R1 R2 R3 R4 R5: sweep ratios 1..3, alternating chains; R8: other chain idle.
    for (int n = 1; n <= 3; n++)
      for (int m = 1; m <= 3; m++)
        for (int o = 1; o <= 3; o++) begin
          int ch;
          ch = (n + m + o) % 2;
          writeCfg(ch, n, m, o);
          expN[ch] = n; expM[ch] = m; expO[ch] = o;
          expAct[ch] = 1; expAct[1-ch] = 0;
          startMask(ch == 0 ? 2'b01 : 2'b10);
          observe(2 * n * m * o + 3);
          judge("R1 R2 R3 R4 R5 R8 sweep");
          stopAll();
        end

    // R3 R8: wide 8 kHz settings on both chains simultaneously.
    writeCfg(0, 2, 2, 768);
    writeCfg(1, 2, 6, 256);
    expN[0] = 2; expM[0] = 2; expO[0] = 768; expAct[0] = 1;
    expN[1] = 2; expM[1] = 6; expO[1] = 256; expAct[1] = 1;
    startMask(2'b11);
    observe(6150);
    judge("R3 R8 both chains 3072-cycle strobe");
    stopAll();

    // R4 R10: restart after stop begins from zero; alternative record factors.
    writeCfg(1, 2, 12, 128);
    expN[1] = 2; expM[1] = 12; expO[1] = 128;
    startMask(2'b11);
    observe(3080);
    judge("R4 R10 restart and 2x12x128 record");
    stopAll();

    // R6: write during run is ignored.
    writeCfg(0, 2, 3, 2);
    expN[0] = 2; expM[0] = 3; expO[0] = 2; expAct[0] = 1; expAct[1] = 0;
    startMask(2'b01);
    observe(7);
    @(negedge clk);
    cfgWe[0] = 1'b1; cfgN[0] = NW'(1); cfgM[0] = MW'(1); cfgOsr[0] = OW'(1);
    observe(1);
    @(negedge clk); cfgWe[0] = 1'b0;
    observe(20);
    judge("R6 write while running ignored");
    stopAll();
    startMask(2'b01);
    observe(25);
    judge("R6 old ratios kept after restart");
    stopAll();
    writeCfg(0, 3, 1, 2);
    expN[0] = 3; expM[0] = 1; expO[0] = 2;
    startMask(2'b01);
    observe(20);
    judge("R6 write while stopped applies");
    stopAll();

    // R7: a zero in any field keeps the chain idle; R8: other chain keeps running.
    for (int z = 0; z < 3; z++) begin
      writeCfg(1, z == 0 ? 0 : 2, z == 1 ? 0 : 2, z == 2 ? 0 : 2);
      expAct[1] = 0; expAct[0] = 1;
      startMask(2'b11);
      observe(30);
      judge("R7 zero ratio idles chain, R8 chain0 unaffected");
      stopAll();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule